// File: doc/BRIEF.md
# Four-Channel DMA Transfer Sequencer

This block sequences single DMA transfers for four channels. Each channel holds a mode, a current and a base address, and a current and a base count. A channel asks for service from its external request line or from a software request line, and a mask line can hold it back. On each `start_i` pulse the sequencer picks the highest-priority unmasked requester. It issues exactly one bus cycle of the kind that channel's mode selects. It then writes the stepped address and count back into the channel.

The block does not run the memory bus or the device handshake. For one cycle it gives a start strobe together with the cycle kind, the channel number, a 24-bit physical address and a terminal-count flag. Byte channels join an 8-bit page to the 16-bit address. Word channels drop page bit 0 and shift the address left by one, so they address words inside 128K pages. A parameter mask chooses which channels are word channels (channels 2 and 3 by default).

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, `cyc_start_o`, `done_o` and `err_o` are low. All channel registers are zero.
- R2: When `start_i` is sampled high in the idle state and at least one channel is pending, `cyc_start_o` is high for exactly one cycle, starting the cycle after that edge. `done_o` is high for exactly the following cycle. A start with no pending channel produces no strobe, no done and no error. Each start gives at most one transfer.
- R3: Mode bits [1:0] give the cycle kind on `cyc_kind_o`: 00 verify, 01 write to memory, 10 read from memory. Kind 11 is illegal. It gives a one-cycle `err_o` pulse in the cycle after the start edge, with no strobe and no done.
- R4: A channel is pending when (`dreq_i` or `swreq_i`) is set and `mask_i` is clear. The lowest pending channel number wins, and `cyc_ch_o` reports it.
- R5: `cyc_tc_o` is high during the strobe exactly when the channel's current count is 0x0000.
- R6: After a transfer, the current address decrements if mode bit 3 is 1 and increments otherwise. It wraps modulo 2^16.
- R7: After a transfer, the current count decrements by one. A loaded count N yields terminal count on transfer N+1.
- R8: If mode bit 2 (auto-reload) is set and a transfer is issued at count 0x0000, the current address and count both reload from their base values instead of stepping.
- R9: On a byte channel, `cyc_addr_o` = {page[7:0], addr[15:0]}.
- R10: On a word channel, `cyc_addr_o` = {page[7:1], addr[15:0], 0}. Page bit 0 is ignored.
- R11: A load (`ld_en_i`) writes the mode, and sets both the current and the base value of the address and of the count for channel `ld_ch_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one arbitration and transfer |
| dreq_i | input | 4 | External request per channel |
| swreq_i | input | 4 | Software request per channel |
| mask_i | input | 4 | Per-channel mask, 1 blocks service |
| page_i | input | 32 | Page byte per channel, channel n at bits [8n+7:8n] |
| ld_en_i | input | 1 | Load strobe for channel programming |
| ld_ch_i | input | 2 | Channel to load |
| ld_mode_i | input | 4 | Mode: [1:0] kind, [2] auto-reload, [3] decrement |
| ld_addr_i | input | 16 | Start address (current and base) |
| ld_cnt_i | input | 16 | Transfer count minus one (current and base) |
| cyc_start_o | output | 1 | One-cycle bus cycle start strobe |
| cyc_kind_o | output | 2 | Cycle kind, valid with strobe |
| cyc_ch_o | output | 2 | Serviced channel, valid with strobe |
| cyc_addr_o | output | 24 | Physical address, valid with strobe |
| cyc_tc_o | output | 1 | Terminal count, valid with strobe |
| done_o | output | 1 | Write-back completed |
| err_o | output | 1 | Illegal mode request rejected |

## Verification
A wrong stored address or count stays hidden until the channel is next serviced. A wrong address then shows on `cyc_addr_o` at the next strobe of that channel. A wrong count shows later, as a terminal-count flag that comes early, comes late or is missing. A broken auto-reload shows as the address failing to return to its base on the transfer after terminal count. A slip in the sequencing state shows within one or two cycles of a start, as a missing or doubled strobe or done pulse.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      XK_VERIFY  = 2'b00,
      XK_WRITE   = 2'b01,
      XK_READ    = 2'b10,
      XK_ILLEGAL = 2'b11
   } xfer_kind_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_ISSUE,
      SQ_DONE,
      SQ_FAULT
   } seq_state_e;

   localparam int MODE_W        = 4;
   localparam int MODE_AUTO_BIT = 2;
   localparam int MODE_DOWN_BIT = 3;

endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
   parameter int N     = 4,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   if (N < 1) begin : g_bad_n
      $error("dma_prio_arb: N must be at least 1");
   end

   // Lowest index wins: scan downward so the last hit is the smallest.
   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            idx      = IDX_W'(i);
         end
      end
      any = |req;
   end

   a_r4_grant_onehot : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   a_r4_grant_from_req : assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0);
   a_r4_grant_when_any : assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (grant != '0));

endmodule

// File: rtl/dma_phys_addr.sv
module dma_phys_addr #(
   parameter int PAGE_W  = 8,
   parameter int ADDR_W  = 16,
   parameter bit WORD_CH = 1'b0,
   localparam int PHYS_W = PAGE_W + ADDR_W
) (
   input  logic [PAGE_W-1:0] page,
   input  logic [ADDR_W-1:0] addr,
   output logic [PHYS_W-1:0] phys
);

   if (PAGE_W < 2) begin : g_bad_page
      $error("dma_phys_addr: PAGE_W must be at least 2");
   end

   if (WORD_CH) begin : g_word
      // Word channel: the address counts words; page bit 0 plays no part.
      assign phys = {page[PAGE_W-1:1], addr, page[0] & 1'b0};
   end else begin : g_byte
      assign phys = {page, addr};
   end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [MODE_W-1:0] ld_mode,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [CNT_W-1:0]  ld_cnt,
   input  logic              step_en,
   output logic [MODE_W-1:0] mode_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  cnt_o
);

   logic [MODE_W-1:0] mode_q;
   logic [ADDR_W-1:0] base_addr_q, cur_addr_q, addr_next;
   logic [CNT_W-1:0]  base_cnt_q, cur_cnt_q;
   logic              reload;

   assign reload    = mode_q[MODE_AUTO_BIT] && (cur_cnt_q == '0);
   assign addr_next = mode_q[MODE_DOWN_BIT] ? cur_addr_q - 1'b1 : cur_addr_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q      <= '0;
         base_addr_q <= '0;
         cur_addr_q  <= '0;
         base_cnt_q  <= '0;
         cur_cnt_q   <= '0;
      end else if (ld_en) begin
         mode_q      <= ld_mode;
         base_addr_q <= ld_addr;
         cur_addr_q  <= ld_addr;
         base_cnt_q  <= ld_cnt;
         cur_cnt_q   <= ld_cnt;
      end else if (step_en) begin
         if (reload) begin
            cur_addr_q <= base_addr_q;
            cur_cnt_q  <= base_cnt_q;
         end else begin
            cur_addr_q <= addr_next;
            cur_cnt_q  <= cur_cnt_q - 1'b1;
         end
      end
   end

   assign mode_o = mode_q;
   assign addr_o = cur_addr_q;
   assign cnt_o  = cur_cnt_q;

   a_r7_count_steps : assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !ld_en && !(mode_o[MODE_AUTO_BIT] && cnt_o == '0))
      |=> (cnt_o == $past(cnt_o) - 1'b1));
   a_r8_reload_base : assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !ld_en && mode_o[MODE_AUTO_BIT] && cnt_o == '0)
      |=> (cnt_o == base_cnt_q && addr_o == base_addr_q));
   a_r11_load_both : assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (addr_o == base_addr_q && cnt_o == base_cnt_q));

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
   import dma_seq_pkg::*;
#(
   parameter int NUM_CH                    = 4,
   parameter int ADDR_W                    = 16,
   parameter int CNT_W                     = 16,
   parameter int PAGE_W                    = 8,
   parameter logic [NUM_CH-1:0] WORD_CH_MASK = 4'b1100,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int PHYS_W = PAGE_W + ADDR_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [NUM_CH-1:0]        dreq_i,
   input  logic [NUM_CH-1:0]        swreq_i,
   input  logic [NUM_CH-1:0]        mask_i,
   input  logic [NUM_CH*PAGE_W-1:0] page_i,
   input  logic                     ld_en_i,
   input  logic [CH_W-1:0]          ld_ch_i,
   input  logic [MODE_W-1:0]        ld_mode_i,
   input  logic [ADDR_W-1:0]        ld_addr_i,
   input  logic [CNT_W-1:0]         ld_cnt_i,
   output logic                     cyc_start_o,
   output logic [1:0]               cyc_kind_o,
   output logic [CH_W-1:0]          cyc_ch_o,
   output logic [PHYS_W-1:0]        cyc_addr_o,
   output logic                     cyc_tc_o,
   output logic                     done_o,
   output logic                     err_o
);

   if (NUM_CH < 1 || NUM_CH > (1 << CH_W)) begin : g_bad_ch
      $error("dma_xfer_seq: NUM_CH out of range");
   end
   if (CNT_W < 1 || ADDR_W < 1) begin : g_bad_w
      $error("dma_xfer_seq: widths must be positive");
   end

   logic [MODE_W-1:0] mode_arr [NUM_CH];
   logic [ADDR_W-1:0] addr_arr [NUM_CH];
   logic [CNT_W-1:0]  cnt_arr  [NUM_CH];
   logic [PHYS_W-1:0] phys_arr [NUM_CH];
   logic [NUM_CH-1:0] step_vec;

   seq_state_e        state_q;
   logic [CH_W-1:0]   sel_q;

   logic [NUM_CH-1:0] pending, grant;
   logic              grant_any;
   logic [CH_W-1:0]   grant_idx;
   xfer_kind_e        win_kind;

   assign pending = (dreq_i | swreq_i) & ~mask_i;

   dma_prio_arb #(.N(NUM_CH)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (pending),
      .grant (grant),
      .any   (grant_any),
      .idx   (grant_idx)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .ld_en   (ld_en_i && (ld_ch_i == CH_W'(c))),
         .ld_mode (ld_mode_i),
         .ld_addr (ld_addr_i),
         .ld_cnt  (ld_cnt_i),
         .step_en (step_vec[c]),
         .mode_o  (mode_arr[c]),
         .addr_o  (addr_arr[c]),
         .cnt_o   (cnt_arr[c])
      );

      dma_phys_addr #(
         .PAGE_W  (PAGE_W),
         .ADDR_W  (ADDR_W),
         .WORD_CH (WORD_CH_MASK[c])
      ) u_map (
         .page (page_i[c*PAGE_W +: PAGE_W]),
         .addr (addr_arr[c]),
         .phys (phys_arr[c])
      );

      assign step_vec[c] = (state_q == SQ_ISSUE) && (sel_q == CH_W'(c));
   end

   assign win_kind = xfer_kind_e'(mode_arr[grant_idx][1:0]);

   // Sequencer: decide in idle, strobe for one cycle, write back, report.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         sel_q   <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (start_i && grant_any) begin
                  sel_q   <= grant_idx;
                  state_q <= (win_kind == XK_ILLEGAL) ? SQ_FAULT : SQ_ISSUE;
               end
            end
            SQ_ISSUE: state_q <= SQ_DONE;
            SQ_DONE:  state_q <= SQ_IDLE;
            SQ_FAULT: state_q <= SQ_IDLE;
            default:  state_q <= SQ_IDLE;
         endcase
      end
   end

   assign cyc_start_o = (state_q == SQ_ISSUE);
   assign cyc_kind_o  = mode_arr[sel_q][1:0];
   assign cyc_ch_o    = sel_q;
   assign cyc_addr_o  = phys_arr[sel_q];
   assign cyc_tc_o    = cyc_start_o && (cnt_arr[sel_q] == '0);
   assign done_o      = (state_q == SQ_DONE);
   assign err_o       = (state_q == SQ_FAULT);

   a_r2_single_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start_o |=> !cyc_start_o);
   a_r2_done_follows : assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start_o |=> done_o);
   a_r2_done_needs_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(cyc_start_o));
   a_r3_err_excl : assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!cyc_start_o && !done_o));
   a_r3_kind_legal : assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start_o |-> (cyc_kind_o != XK_ILLEGAL));
   a_r2_start_needs_pending : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cyc_start_o) |-> $past(start_i && pending != '0));

endmodule

// File: tb/tb_dma_xfer_seq.sv
module tb_dma_xfer_seq;

   localparam logic [3:0] WORD = 4'b1100;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i;
   logic [3:0]  dreq_i, swreq_i, mask_i;
   logic [31:0] page_i;
   logic        ld_en_i;
   logic [1:0]  ld_ch_i;
   logic [3:0]  ld_mode_i;
   logic [15:0] ld_addr_i, ld_cnt_i;
   logic        cyc_start_o, cyc_tc_o, done_o, err_o;
   logic [1:0]  cyc_kind_o, cyc_ch_o;
   logic [23:0] cyc_addr_o;

   always #4 clk = ~clk;

   dma_xfer_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dreq_i(dreq_i),
      .swreq_i(swreq_i), .mask_i(mask_i), .page_i(page_i),
      .ld_en_i(ld_en_i), .ld_ch_i(ld_ch_i), .ld_mode_i(ld_mode_i),
      .ld_addr_i(ld_addr_i), .ld_cnt_i(ld_cnt_i),
      .cyc_start_o(cyc_start_o), .cyc_kind_o(cyc_kind_o),
      .cyc_ch_o(cyc_ch_o), .cyc_addr_o(cyc_addr_o), .cyc_tc_o(cyc_tc_o),
      .done_o(done_o), .err_o(err_o)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [3:0]  m_mode [4];
   logic [15:0] m_addr [4], m_cnt [4], m_badr [4], m_bcnt [4];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_phys(input int ch);
      logic [7:0] pg;
      pg = page_i[ch*8 +: 8];
      if (WORD[ch]) return {pg[7:1], m_addr[ch], 1'b0};
      return {pg, m_addr[ch]};
   endfunction

   function automatic int exp_winner(input logic [3:0] pend);
      for (int i = 0; i < 4; i++) if (pend[i]) return i;
      return -1;
   endfunction

   task automatic model_step(input int ch);
      if (m_mode[ch][2] && m_cnt[ch] == 16'h0000) begin
         m_addr[ch] = m_badr[ch];
         m_cnt[ch]  = m_bcnt[ch];
      end else begin
         m_addr[ch] = m_mode[ch][3] ? m_addr[ch] - 16'd1 : m_addr[ch] + 16'd1;
         m_cnt[ch]  = m_cnt[ch] - 16'd1;
      end
   endtask

   task automatic do_load(input int ch, input logic [3:0] md, input logic [15:0] a,
                          input logic [15:0] n);
      @(negedge clk);
      ld_en_i = 1'b1; ld_ch_i = 2'(ch); ld_mode_i = md; ld_addr_i = a; ld_cnt_i = n;
      @(negedge clk);
      ld_en_i = 1'b0;
      m_mode[ch] = md; m_addr[ch] = a; m_badr[ch] = a; m_cnt[ch] = n; m_bcnt[ch] = n;
   endtask

   task automatic run_start();
      logic [3:0] pend;
      int w;
      pend = (dreq_i | swreq_i) & ~mask_i;
      w = exp_winner(pend);
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      if (w < 0) begin
         chk(cyc_start_o == 1'b0 && err_o == 1'b0, "R2 idle start", cyc_start_o, 0);
         @(negedge clk);
         chk(done_o == 1'b0, "R2 no done", done_o, 0);
         return;
      end
      if (m_mode[w][1:0] == 2'b11) begin
         chk(err_o == 1'b1 && cyc_start_o == 1'b0, "R3 illegal err", {err_o, cyc_start_o}, 2'b10);
         @(negedge clk);
         chk(done_o == 1'b0 && err_o == 1'b0, "R3 illegal no done", {done_o, err_o}, 0);
         return;
      end
      chk(cyc_start_o == 1'b1, "R2 strobe", cyc_start_o, 1);
      chk(cyc_ch_o == 2'(w), "R4 winner", cyc_ch_o, w);
      chk(cyc_kind_o == m_mode[w][1:0], "R3 kind", cyc_kind_o, m_mode[w][1:0]);
      if (WORD[w]) chk(cyc_addr_o == exp_phys(w), "R10 word addr", cyc_addr_o, exp_phys(w));
      else         chk(cyc_addr_o == exp_phys(w), "R9 byte addr", cyc_addr_o, exp_phys(w));
      chk(cyc_tc_o == (m_cnt[w] == 16'h0000), "R5 tc", cyc_tc_o, m_cnt[w] == 16'h0000);
      model_step(w);
      @(negedge clk);
      chk(done_o == 1'b1 && cyc_start_o == 1'b0, "R2 done", {done_o, cyc_start_o}, 2'b10);
      @(negedge clk);
      chk(done_o == 1'b0, "R2 done once", done_o, 0);
   endtask

   task automatic set_req(input logic [3:0] d, input logic [3:0] s, input logic [3:0] m);
      dreq_i = d; swreq_i = s; mask_i = m;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd715);
      rst_n = 1'b0; start_i = 1'b0; set_req(4'h0, 4'h0, 4'h0);
      ld_en_i = 1'b0; ld_ch_i = '0; ld_mode_i = '0; ld_addr_i = '0; ld_cnt_i = '0;
      page_i = 32'h35_77_81_12;
      for (int i = 0; i < 4; i++) begin
         m_mode[i] = '0; m_addr[i] = '0; m_cnt[i] = '0; m_badr[i] = '0; m_bcnt[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cyc_start_o == 0 && done_o == 0 && err_o == 0, "R1 reset outputs",
          {cyc_start_o, done_o, err_o}, 0);

      // R1: registers cleared, channel 0 verify at address 0, tc at count 0
      set_req(4'h1, 4'h0, 4'h0);
      run_start();

      // R2: no pending channel
      set_req(4'h0, 4'h0, 4'h0);
      run_start();
      set_req(4'hF, 4'h0, 4'hF);
      run_start();

      // R9 R6 R7 R5: byte channel, increment across 0xFFFF, count 1 -> tc on 2nd
      do_load(0, 4'b0010, 16'hFFFF, 16'h0001);
      set_req(4'h1, 4'h0, 4'h0);
      run_start();
      run_start();
      chk(m_addr[0] == 16'h0001, "R6 wrap inc model", m_addr[0], 16'h0001);

      // R10 R8: word channel, write, decrement, auto-reload at count 0
      do_load(2, 4'b1101, 16'h0000, 16'h0000);
      set_req(4'h0, 4'h4, 4'h0);
      run_start();
      run_start();
      // R10 R6: no reload, decrement wraps to 0xFFFF, page bit 0 ignored
      do_load(3, 4'b1000, 16'h0000, 16'h0005);
      set_req(4'h8, 4'h0, 4'h0);
      run_start();
      run_start();

      // R4: masked channel 0 skipped, channel 1 beats channel 3
      do_load(1, 4'b0001, 16'h1234, 16'h0010);
      set_req(4'b0011, 4'b1000, 4'b0001);
      run_start();
      // R4: software request alone
      set_req(4'b0000, 4'b0010, 4'b0000);
      run_start();

      // R3: illegal kind
      do_load(1, 4'b0011, 16'h0040, 16'h0002);
      set_req(4'b0010, 4'b0000, 4'b0000);
      run_start();
      // R11: reload channel 1 legal, address and count restart from loaded values
      do_load(1, 4'b0000, 16'h0040, 16'h0000);
      run_start();

      // Random mix
      for (int it = 0; it < 400; it++) begin
         if ($urandom_range(0, 3) == 0) begin
            int ch;
            logic [3:0] md;
            logic [15:0] n;
            ch = $urandom_range(0, 3);
            md = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 7) != 0 && md[1:0] == 2'b11) md[1:0] = 2'b01;
            n = ($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 3)) : 16'($urandom);
            do_load(ch, md, 16'($urandom), n);
         end
         set_req(4'($urandom), 4'($urandom_range(0, 15) & 4'($urandom)), 4'($urandom));
         run_start();
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule